// File: doc/BRIEF.md
# ADC Overload Flag and Startup Output Blanker

This block sits after the decimation stage of a stereo audio ADC. It sees one left and one right sample per frame, qualified by a sample strobe. When the magnitude of either channel rises above a level just under digital full scale, it raises an overload flag. The flag is kept high for a fixed number of sample periods after the most recent offending sample, so firmware or an LED driver can watch it without sampling every frame. Each new offending sample restarts that hold time.

The block also keeps the converted data from reaching the serial formatter until the filter chain has settled: after reset (standing in for the system clock starting) and after the ADC leaves power-down, the outputs are forced to zero for a settling interval counted in sample periods. The interval is longer when the DC-removal high-pass filter is on. All timing advances only on the sample strobe, so durations follow the sampling rate rather than the system clock.

Top module: `adc_ovl_blank`

## Requirements
- R1: A strobed sample whose magnitude is strictly greater than THR = floor(7 * (2^(W-1) - 1) / 8) (458751 for W = 20) on either channel sets `ovl_flag` high from the next clock; a magnitude equal to THR does not.
- R2: Samples are two's complement; negative samples are judged by their magnitude, and the most negative code (magnitude 2^(W-1)) counts as an overload.
- R3: After the last overloading strobe, `ovl_flag` stays high through the following HOLD - 1 strobes and goes low on the HOLD-th one (HOLD = 512).
- R4: An overloading sample on either channel while the flag is high restarts the full HOLD count.
- R5: With `dc_en` low, `data_ok` stays low and `out_l`/`out_r` are zero until BLANK_OFF (1024) strobes have been seen after reset or power-down release; from then on `out_l`/`out_r` follow `smp_l`/`smp_r`.
- R6: With `dc_en` high, the blanking interval is BLANK_ON (12288) strobes.
- R7: A change of `dc_en` while blanking reloads the interval for the new setting; a change after blanking has ended leaves `data_ok` high.
- R8: While `pwr_dn` is high, `ovl_flag` is low, overloading samples are ignored, `data_ok` is low, and the blanking count is held at its full reload value.
- R9: Clock cycles without `smp_stb` neither detect overload nor advance the hold or blanking counts.
- R10: A synchronous reset (`rst_n` low) leaves `ovl_flag` low and `data_ok` low with zero outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_dn | input | 1 | ADC power-down |
| dc_en | input | 1 | DC-removal filter enabled (selects long blanking) |
| smp_stb | input | 1 | One-cycle strobe marking a new stereo sample |
| smp_l | input | W | Left sample, two's complement |
| smp_r | input | W | Right sample, two's complement |
| ovl_flag | output | 1 | Overload indication with retriggerable hold |
| data_ok | output | 1 | High once settling is complete |
| out_l | output | W | Left sample, zero while blanked |
| out_r | output | W | Right sample, zero while blanked |

## Verification
On every cycle the assertions check that power-down clears the flag and blanks the outputs, that an above-threshold strobed sample always raises the flag, that the flag and `data_ok` can only rise after a strobe, and that once valid the data stays valid until power-down. The exact lengths of the hold and blanking windows, the retrigger restart, the equal-to-threshold boundary and the reload on a DC-filter change are shown only by the bench's directed scenarios, which count strobes and look at the cycle where the output must change.

// File: rtl/adc_ovl_blank.sv
module adc_ovl_blank #(
  parameter int W         = 20,
  parameter int HOLD      = 512,
  parameter int BLANK_OFF = 1024,
  parameter int BLANK_ON  = 12288
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pwr_dn,
  input  logic         dc_en,
  input  logic         smp_stb,
  input  logic [W-1:0] smp_l,
  input  logic [W-1:0] smp_r,
  output logic         ovl_flag,
  output logic         data_ok,
  output logic [W-1:0] out_l,
  output logic [W-1:0] out_r
);
  localparam int HW   = $clog2(HOLD + 1);
  localparam int BMAX = (BLANK_ON > BLANK_OFF) ? BLANK_ON : BLANK_OFF;
  localparam int BW   = $clog2(BMAX + 1);
  localparam logic [W+2:0] FS7 = {4'b0000, {(W-1){1'b1}}} * 7;
  localparam logic [W-1:0] THR = W'(FS7 >> 3);

  function automatic logic [W-1:0] mag(input logic [W-1:0] x);
    return x[W-1] ? (~x + 1'b1) : x;
  endfunction

  logic [HW-1:0] hold_cnt;
  logic [BW-1:0] blank_cnt;
  logic [BW-1:0] reload;
  logic          dc_q;
  logic          over;

  assign over   = (mag(smp_l) > THR) || (mag(smp_r) > THR);
  assign reload = dc_en ? BW'(BLANK_ON) : BW'(BLANK_OFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_cnt  <= '0;
      blank_cnt <= reload;
      dc_q      <= dc_en;
    end else begin
      dc_q <= dc_en;
      if (pwr_dn) begin
        hold_cnt  <= '0;
        blank_cnt <= reload;
      end else begin
        if (smp_stb) begin
          if (over)
            hold_cnt <= HW'(HOLD);
          else if (hold_cnt != '0)
            hold_cnt <= hold_cnt - 1'b1;
        end
        if (dc_en != dc_q && blank_cnt != '0)
          blank_cnt <= reload;
        else if (smp_stb && blank_cnt != '0)
          blank_cnt <= blank_cnt - 1'b1;
      end
    end
  end

  assign ovl_flag = hold_cnt != '0;
  assign data_ok  = blank_cnt == '0;
  assign out_l    = data_ok ? smp_l : '0;
  assign out_r    = data_ok ? smp_r : '0;
endmodule

// File: rtl/adc_ovl_blank_chk.sv
module adc_ovl_blank_chk #(
  parameter int W = 20
) (
  input logic         clk,
  input logic         rst_n,
  input logic         pwr_dn,
  input logic         smp_stb,
  input logic [W-1:0] smp_l,
  input logic [W-1:0] smp_r,
  input logic         ovl_flag,
  input logic         data_ok,
  input logic [W-1:0] out_l,
  input logic [W-1:0] out_r
);
  localparam longint FSC = (longint'(1) << (W - 1)) - 1;
  localparam longint TH  = (FSC * 7) / 8;

  function automatic longint absval(input logic [W-1:0] x);
    return x[W-1] ? (longint'(1) << W) - longint'(x) : longint'(x);
  endfunction

  logic big;
  assign big = (absval(smp_l) > TH) || (absval(smp_r) > TH);

  p_over_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb && !pwr_dn && big |=> ovl_flag);
  p_flag_clr_pwrdn_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> !ovl_flag);
  p_blank_pwrdn_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> !data_ok && out_l == '0 && out_r == '0);
  p_flag_rise_stb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovl_flag) |-> $past(smp_stb));
  p_ok_rise_stb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_ok) |-> $past(smp_stb));
  p_ok_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    data_ok && !pwr_dn |=> data_ok);
endmodule

bind adc_ovl_blank adc_ovl_blank_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .smp_stb(smp_stb),
  .smp_l(smp_l), .smp_r(smp_r), .ovl_flag(ovl_flag), .data_ok(data_ok),
  .out_l(out_l), .out_r(out_r)
);

// File: tb/sim_adc_ovl_blank.sv
module sim_adc_ovl_blank;
  localparam int W = 20;
  localparam logic [W-1:0] THR  = 20'd458751;
  localparam logic [W-1:0] MOST = 20'h80000;

  logic clk = 1'b0;
  logic rst_n, pwr_dn, dc_en, smp_stb;
  logic [W-1:0] smp_l, smp_r;
  logic ovl_flag, data_ok;
  logic [W-1:0] out_l, out_r;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  adc_ovl_blank u0 (
    .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .dc_en(dc_en),
    .smp_stb(smp_stb), .smp_l(smp_l), .smp_r(smp_r),
    .ovl_flag(ovl_flag), .data_ok(data_ok), .out_l(out_l), .out_r(out_r)
  );

  function automatic logic [W-1:0] neg(input logic [W-1:0] v);
    return ~v + 1'b1;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input logic s, input logic [W-1:0] l, input logic [W-1:0] r);
    smp_stb = s; smp_l = l; smp_r = r;
    @(negedge clk);
    smp_stb = 1'b0;
  endtask

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) tick(1'b1, '0, '0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; pwr_dn = 1'b0; dc_en = 1'b0;
    tick(1'b0, 20'd5, 20'd5);
    tick(1'b0, 20'd5, 20'd5);
    rst_n = 1'b1;
    smp_l = 20'd77;
    #0.5;
    chk("R10 flag", ovl_flag, 0);
    chk("R10 data_ok", data_ok, 0);
    chk("R10 out_l", out_l, 0);
  endtask

  task automatic t_blank_off();
    quiet(1023);
    chk("R5 blank at 1023", data_ok, 0);
    quiet(1);
    chk("R5 ok at 1024", data_ok, 1);
    smp_l = 20'd123; smp_r = 20'd456;
    #0.5;
    chk("R5 out_l passes", out_l, 123);
    chk("R5 out_r passes", out_r, 456);
  endtask

  task automatic t_threshold();
    tick(1'b1, THR, 20'd0);
    chk("R1 equal no flag", ovl_flag, 0);
    tick(1'b1, 20'd0, THR + 1'b1);
    chk("R1 above sets flag", ovl_flag, 1);
    quiet(511);
    chk("R3 held 511", ovl_flag, 1);
    quiet(1);
    chk("R3 drop at 512", ovl_flag, 0);
  endtask

  task automatic t_negative();
    tick(1'b1, neg(THR), 20'd0);
    chk("R2 neg equal no flag", ovl_flag, 0);
    tick(1'b1, neg(THR + 1'b1), 20'd0);
    chk("R2 neg above", ovl_flag, 1);
    quiet(512);
    chk("R2 cleared", ovl_flag, 0);
    tick(1'b1, 20'd0, MOST);
    chk("R2 most negative", ovl_flag, 1);
    quiet(512);
  endtask

  task automatic t_retrigger();
    tick(1'b1, MOST, 20'd0);
    quiet(300);
    tick(1'b1, 20'd0, 20'h7FFFF);
    quiet(511);
    chk("R4 restarted 511", ovl_flag, 1);
    quiet(1);
    chk("R4 drop after restart", ovl_flag, 0);
  endtask

  task automatic t_no_strobe();
    tick(1'b0, 20'h7FFFF, MOST);
    chk("R9 no strobe no flag", ovl_flag, 0);
    tick(1'b1, 20'h7FFFF, 20'd0);
    for (int i = 0; i < 1000; i++) tick(1'b0, '0, '0);
    chk("R9 hold frozen", ovl_flag, 1);
    quiet(511);
    chk("R9 hold 511", ovl_flag, 1);
    quiet(1);
    chk("R9 drop 512", ovl_flag, 0);
  endtask

  task automatic t_pwrdn_on();
    tick(1'b1, 20'h7FFFF, 20'd0);
    dc_en = 1'b1; pwr_dn = 1'b1;
    tick(1'b0, '0, '0);
    chk("R8 flag cleared", ovl_flag, 0);
    chk("R8 blanked", data_ok, 0);
    tick(1'b1, MOST, MOST);
    chk("R8 overload ignored", ovl_flag, 0);
    quiet(50);
    pwr_dn = 1'b0;
    quiet(12287);
    chk("R6 blank at 12287", data_ok, 0);
    chk("R8 reload held", out_l, 0);
    quiet(1);
    chk("R6 ok at 12288", data_ok, 1);
  endtask

  task automatic t_dc_change();
    pwr_dn = 1'b1;
    tick(1'b0, '0, '0);
    pwr_dn = 1'b0;
    quiet(100);
    dc_en = 1'b0;
    tick(1'b0, '0, '0);
    quiet(1023);
    chk("R7 reload blank 1023", data_ok, 0);
    quiet(1);
    chk("R7 reload ok 1024", data_ok, 1);
    dc_en = 1'b1;
    tick(1'b0, '0, '0);
    quiet(3);
    chk("R7 late change no effect", data_ok, 1);
  endtask

  initial begin
    smp_stb = 1'b0; smp_l = '0; smp_r = '0;
    rst_n = 1'b0; pwr_dn = 1'b0; dc_en = 1'b0;
    @(negedge clk);
    t_reset();
    t_blank_off();
    t_threshold();
    t_negative();
    t_retrigger();
    t_no_strobe();
    t_pwrdn_on();
    t_dc_change();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule